// File: doc/BRIEF.md
# Voltage-Dip Ride-Through Mode Controller

This block decides, sample by sample, how a grid-tied converter behaves when the voltage at its connection point sags. It takes one voltage magnitude per sample strobe. While the voltage is healthy it passes the d/q current references through unchanged. When the voltage falls under a configured dip level, it enters a ride-through mode. In that mode the converter stays connected, and the current references are bounded by a magnitude envelope that serves reactive current first.

Leaving ride-through happens in two steps. The voltage must first climb above a higher recovery level, which adds hysteresis, and then hold there for a programmed number of consecutive samples. A dip that outlasts a programmed sample budget ends in a sticky tripped state, and only reset clears it. Entry and exit each raise a one-cycle event pulse for an external logger. On every sample the block also compares a waveform-quality figure to a threshold and raises a request asking the phase-tracking loop to hold its angle.

The envelope uses an iterative square root, so the limited references appear a fixed number of cycles after each sample and are marked by a valid pulse.

Top module: `ridethru_ctrl`

## Requirements
- R1: The mode output uses 2'b00 for normal, 2'b01 for ride-through, 2'b10 for recovery and 2'b11 for tripped. A sample with `v_mag < cfg_v_dip` taken in normal mode moves the mode to 2'b01. A sample equal to the dip level does not.
- R2: In ride-through and recovery modes, `iq_lim` equals `iq_ref` saturated to ±`cfg_i_max`.
- R3: In ride-through and recovery modes, `id_lim` equals `id_ref` saturated to ±floor(sqrt(`cfg_i_max`² − `iq_lim`²)). It may therefore be zero or negative.
- R4: In normal mode, `id_lim` and `iq_lim` equal `id_ref` and `iq_ref` unchanged.
- R5: Ride-through moves to recovery (2'b10) only on a sample with `v_mag >= cfg_v_dip + cfg_v_hyst`. A sample between the two levels keeps the mode at 2'b01.
- R6: Recovery returns to normal once `cfg_recov_n` consecutive samples sit at or above the recovery level. A sample between the levels restarts that count. A sample below the dip level sends the mode back to 2'b01 with no new entry event.
- R7: `ev_enter` is high for exactly the one cycle after the sample that enters ride-through from normal. `ev_exit` is high for exactly the one cycle after the sample that returns the mode to normal.
- R8: The sample that enters ride-through counts as sample one. When more than `cfg_ride_max` samples have passed without a return to normal, the mode becomes 2'b11 and `trip_req` rises. Both stay set until reset, and in that state both limited references are zero.
- R9: On each sample, `freeze_req` becomes 1 if `q_level < cfg_q_min` and 0 otherwise. It holds that value between samples.
- R10: After reset the mode is 2'b00, and all flags, events and limited references are zero. The mode changes only on a sample strobe. `lim_valid` pulses once for each sample that arrives at least 20 cycles after the one before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | One-cycle strobe marking a new sample |
| v_mag | input | VW | Connection-point voltage magnitude |
| q_level | input | QW | Waveform quality figure, higher is better |
| id_ref | input | IW | Active current reference, signed |
| iq_ref | input | IW | Reactive current reference, signed |
| cfg_v_dip | input | VW | Dip detection level |
| cfg_v_hyst | input | VW | Hysteresis added to form the recovery level |
| cfg_recov_n | input | CW | Consecutive good samples needed to leave recovery |
| cfg_ride_max | input | CW | Ride-through sample budget before tripping |
| cfg_i_max | input | IW-1 | Current vector magnitude limit |
| cfg_q_min | input | QW | Quality level under which freeze is requested |
| id_lim | output | IW | Limited active current reference, signed |
| iq_lim | output | IW | Limited reactive current reference, signed |
| lim_valid | output | 1 | Pulse marking new limited references |
| mode | output | 2 | Operating mode code |
| freeze_req | output | 1 | Angle-hold request to the phase-tracking loop |
| trip_req | output | 1 | Sticky trip request |
| ev_enter | output | 1 | Ride-through entry event pulse |
| ev_exit | output | 1 | Ride-through exit event pulse |

## Verification
The bench probes the dip level at exact equality and one count below. A comparator written as `<=` would enter ride-through early. It places samples between the dip and recovery levels, which exposes a design without hysteresis or one whose good-sample count is not restarted. It also drops the voltage back below the dip level during recovery, which catches a design that fires a second entry event. The envelope is checked for a clamped Iq with zero Id headroom and for negative Id in saturation, which catches a design that favours active current or ignores sign. A trip test counts samples exactly at the budget boundary and then applies healthy voltage, so an off-by-one timer or a trip that clears itself would show.

// File: rtl/ridethru_pkg.sv
`timescale 1ns/1ps
package ridethru_pkg;

    typedef enum logic [1:0] {
        RT_NORMAL  = 2'b00,
        RT_RIDE    = 2'b01,
        RT_RECOVER = 2'b10,
        RT_TRIPPED = 2'b11
    } rt_mode_e;

    typedef struct packed {
        logic enter;
        logic leave;
    } rt_evt_s;

    // Modes in which the current envelope applies
    function automatic logic is_limiting(input rt_mode_e m);
        return (m == RT_RIDE) || (m == RT_RECOVER);
    endfunction

endpackage

// File: rtl/ridethru_fsm.sv
`timescale 1ns/1ps
module ridethru_fsm
    import ridethru_pkg::*;
#(
    parameter int VW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_valid,
    input  logic [VW-1:0] v_mag,
    input  logic [VW-1:0] cfg_v_dip,
    input  logic [VW-1:0] cfg_v_hyst,
    input  logic [CW-1:0] cfg_recov_n,
    input  logic [CW-1:0] cfg_ride_max,
    output rt_mode_e      mode,
    output rt_evt_s       evt
);
    localparam int TW = VW + 1;

    rt_mode_e      mode_q, mode_n;
    rt_evt_s       evt_q, evt_n;
    logic [CW:0]   elapsed_q, elapsed_n, elapsed_inc;
    logic [CW-1:0] good_q, good_n;
    logic [CW:0]   good_inc;
    logic [TW-1:0] rec_thr;
    logic          is_dip, is_good, over_budget, good_done;

    assign rec_thr     = {1'b0, cfg_v_dip} + {1'b0, cfg_v_hyst};
    assign is_dip      = v_mag < cfg_v_dip;
    assign is_good     = {1'b0, v_mag} >= rec_thr;
    assign elapsed_inc = elapsed_q + 1'b1;
    assign over_budget = elapsed_inc > {1'b0, cfg_ride_max};
    assign good_inc    = {1'b0, good_q} + 1'b1;
    assign good_done   = good_inc >= {1'b0, cfg_recov_n};

    always_comb begin
        mode_n    = mode_q;
        elapsed_n = elapsed_q;
        good_n    = good_q;
        evt_n     = '0;
        if (smp_valid) begin
            unique case (mode_q)
                RT_NORMAL: begin
                    if (is_dip) begin
                        mode_n      = RT_RIDE;
                        elapsed_n   = {{CW{1'b0}}, 1'b1};
                        good_n      = '0;
                        evt_n.enter = 1'b1;
                    end
                end
                RT_RIDE: begin
                    if (over_budget) begin
                        mode_n = RT_TRIPPED;
                    end else begin
                        elapsed_n = elapsed_inc;
                        if (is_good) begin
                            if (cfg_recov_n <= {{(CW-1){1'b0}}, 1'b1}) begin
                                mode_n      = RT_NORMAL;
                                evt_n.leave = 1'b1;
                            end else begin
                                mode_n = RT_RECOVER;
                                good_n = {{(CW-1){1'b0}}, 1'b1};
                            end
                        end
                    end
                end
                RT_RECOVER: begin
                    if (over_budget) begin
                        mode_n = RT_TRIPPED;
                    end else begin
                        elapsed_n = elapsed_inc;
                        if (is_dip) begin
                            mode_n = RT_RIDE;
                            good_n = '0;
                        end else if (is_good) begin
                            if (good_done) begin
                                mode_n      = RT_NORMAL;
                                evt_n.leave = 1'b1;
                            end else begin
                                good_n = good_inc[CW-1:0];
                            end
                        end else begin
                            good_n = '0;
                        end
                    end
                end
                default: mode_n = RT_TRIPPED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= RT_NORMAL;
            evt_q     <= '0;
            elapsed_q <= '0;
            good_q    <= '0;
        end else begin
            mode_q    <= mode_n;
            evt_q     <= evt_n;
            elapsed_q <= elapsed_n;
            good_q    <= good_n;
        end
    end

    assign mode = mode_q;
    assign evt  = evt_q;

endmodule

// File: rtl/ridethru_isqrt.sv
`timescale 1ns/1ps
module ridethru_isqrt #(
    parameter int RW = 15
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [2*RW-1:0] radicand,
    output logic [RW-1:0]   root,
    output logic            done
);
    localparam int DW = 2 * RW;

    logic [DW-1:0] num_q, res_q, bit_q;
    logic [DW:0]   trial;
    logic          busy_q, done_q;

    assign trial = {1'b0, res_q} + {1'b0, bit_q};

    // One result bit per cycle: RW iterations after start
    always_ff @(posedge clk) begin
        if (rst) begin
            num_q  <= '0;
            res_q  <= '0;
            bit_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                num_q  <= radicand;
                res_q  <= '0;
                bit_q  <= DW'(1) << (DW - 2);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if ({1'b0, num_q} >= trial) begin
                    num_q <= num_q - trial[DW-1:0];
                    res_q <= (res_q >> 1) + bit_q;
                end else begin
                    res_q <= res_q >> 1;
                end
                bit_q <= bit_q >> 2;
                if (bit_q == DW'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign root = res_q[RW-1:0];
    assign done = done_q;

endmodule

// File: rtl/ridethru_limiter.sv
`timescale 1ns/1ps
module ridethru_limiter
    import ridethru_pkg::*;
#(
    parameter int IW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  rt_mode_e             mode,
    input  logic signed [IW-1:0] id_in,
    input  logic signed [IW-1:0] iq_in,
    input  logic [IW-2:0]        i_max,
    output logic signed [IW-1:0] id_out,
    output logic signed [IW-1:0] iq_out,
    output logic                 valid
);
    localparam int RW = IW - 1;
    localparam int DW = 2 * RW;

    logic signed [IW-1:0] lim_s, iq_clip, iq_abs, root_s, id_sat;
    logic [DW-1:0]        max_w, mag_w, radicand;
    logic signed [IW-1:0] id_q, iq_raw_q, iq_clip_q;
    logic [RW-1:0]        root;
    logic                 sq_done;

    assign lim_s   = $signed({1'b0, i_max});
    assign iq_clip = (iq_in > lim_s) ? lim_s : ((iq_in < -lim_s) ? -lim_s : iq_in);
    assign iq_abs  = (iq_clip < 0) ? -iq_clip : iq_clip;
    assign max_w   = DW'(i_max);
    assign mag_w   = DW'(iq_abs[RW-1:0]);
    assign radicand = (max_w * max_w) - (mag_w * mag_w);

    ridethru_isqrt #(.RW(RW)) u_isqrt (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .radicand (radicand),
        .root     (root),
        .done     (sq_done)
    );

    assign root_s = $signed({1'b0, root});
    assign id_sat = (id_q > root_s) ? root_s : ((id_q < -root_s) ? -root_s : id_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            id_q      <= '0;
            iq_raw_q  <= '0;
            iq_clip_q <= '0;
            id_out    <= '0;
            iq_out    <= '0;
            valid     <= 1'b0;
        end else begin
            if (start) begin
                id_q      <= id_in;
                iq_raw_q  <= iq_in;
                iq_clip_q <= iq_clip;
            end
            valid <= sq_done;
            if (sq_done) begin
                if (mode == RT_TRIPPED) begin
                    id_out <= '0;
                    iq_out <= '0;
                end else if (is_limiting(mode)) begin
                    id_out <= id_sat;
                    iq_out <= iq_clip_q;
                end else begin
                    id_out <= id_q;
                    iq_out <= iq_raw_q;
                end
            end
        end
    end

endmodule

// File: rtl/ridethru_ctrl.sv
`timescale 1ns/1ps
module ridethru_ctrl
    import ridethru_pkg::*;
#(
    parameter int VW = 16,
    parameter int QW = 8,
    parameter int IW = 16,
    parameter int CW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_valid,
    input  logic [VW-1:0]        v_mag,
    input  logic [QW-1:0]        q_level,
    input  logic signed [IW-1:0] id_ref,
    input  logic signed [IW-1:0] iq_ref,
    input  logic [VW-1:0]        cfg_v_dip,
    input  logic [VW-1:0]        cfg_v_hyst,
    input  logic [CW-1:0]        cfg_recov_n,
    input  logic [CW-1:0]        cfg_ride_max,
    input  logic [IW-2:0]        cfg_i_max,
    input  logic [QW-1:0]        cfg_q_min,
    output logic signed [IW-1:0] id_lim,
    output logic signed [IW-1:0] iq_lim,
    output logic                 lim_valid,
    output logic [1:0]           mode,
    output logic                 freeze_req,
    output logic                 trip_req,
    output logic                 ev_enter,
    output logic                 ev_exit
);
    rt_mode_e mode_w;
    rt_evt_s  evt_w;
    logic     freeze_q;

    ridethru_fsm #(.VW(VW), .CW(CW)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .smp_valid    (smp_valid),
        .v_mag        (v_mag),
        .cfg_v_dip    (cfg_v_dip),
        .cfg_v_hyst   (cfg_v_hyst),
        .cfg_recov_n  (cfg_recov_n),
        .cfg_ride_max (cfg_ride_max),
        .mode         (mode_w),
        .evt          (evt_w)
    );

    ridethru_limiter #(.IW(IW)) u_lim (
        .clk    (clk),
        .rst    (rst),
        .start  (smp_valid),
        .mode   (mode_w),
        .id_in  (id_ref),
        .iq_in  (iq_ref),
        .i_max  (cfg_i_max),
        .id_out (id_lim),
        .iq_out (iq_lim),
        .valid  (lim_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            freeze_q <= 1'b0;
        end else if (smp_valid) begin
            freeze_q <= q_level < cfg_q_min;
        end
    end

    assign mode       = mode_w;
    assign freeze_req = freeze_q;
    assign trip_req   = (mode_w == RT_TRIPPED);
    assign ev_enter   = evt_w.enter;
    assign ev_exit    = evt_w.leave;

endmodule

// File: rtl/ridethru_chk.sv
`timescale 1ns/1ps
module ridethru_chk #(
    parameter int IW = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 smp_valid,
    input logic [IW-2:0]        cfg_i_max,
    input logic signed [IW-1:0] id_lim,
    input logic signed [IW-1:0] iq_lim,
    input logic                 lim_valid,
    input logic [1:0]           mode,
    input logic                 freeze_req,
    input logic                 trip_req,
    input logic                 ev_enter,
    input logic                 ev_exit
);
    localparam int XW = 2 * IW;

    logic signed [XW-1:0] id_x, iq_x, max_x, vec_sq, max_sq;

    always_comb begin
        id_x   = XW'(id_lim);
        iq_x   = XW'(iq_lim);
        max_x  = XW'($signed({1'b0, cfg_i_max}));
        vec_sq = id_x * id_x + iq_x * iq_x;
        max_sq = max_x * max_x;
    end

    // R1
    enter_from_normal_chk: assert property (@(posedge clk) disable iff (rst)
        ev_enter |-> (mode == 2'b01) && ($past(mode) == 2'b00));

    // R7
    exit_to_normal_chk: assert property (@(posedge clk) disable iff (rst)
        ev_exit |-> (mode == 2'b00) && (($past(mode) == 2'b10) || ($past(mode) == 2'b01)));

    // R3
    envelope_chk: assert property (@(posedge clk) disable iff (rst)
        (lim_valid && ((mode == 2'b01) || (mode == 2'b10))) |-> (vec_sq <= max_sq));

    // R8
    trip_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b11) |=> (mode == 2'b11) && trip_req);

    // R10
    mode_on_sample_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(mode));

    // R9
    freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(freeze_req));

    // R7
    event_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev_enter, ev_exit}));

endmodule

bind ridethru_ctrl ridethru_chk #(.IW(IW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .smp_valid  (smp_valid),
    .cfg_i_max  (cfg_i_max),
    .id_lim     (id_lim),
    .iq_lim     (iq_lim),
    .lim_valid  (lim_valid),
    .mode       (mode),
    .freeze_req (freeze_req),
    .trip_req   (trip_req),
    .ev_enter   (ev_enter),
    .ev_exit    (ev_exit)
);

// File: tb/ridethru_ctrl_tb.sv
`timescale 1ns/1ps
module ridethru_ctrl_tb_top;

    localparam int VW = 16;
    localparam int QW = 8;
    localparam int IW = 16;
    localparam int CW = 16;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 smp_valid = 1'b0;
    logic [VW-1:0]        v_mag = '0;
    logic [QW-1:0]        q_level = '0;
    logic signed [IW-1:0] id_ref = '0;
    logic signed [IW-1:0] iq_ref = '0;
    logic [VW-1:0]        cfg_v_dip = 16'd1000;
    logic [VW-1:0]        cfg_v_hyst = 16'd100;
    logic [CW-1:0]        cfg_recov_n = 16'd3;
    logic [CW-1:0]        cfg_ride_max = 16'd20;
    logic [IW-2:0]        cfg_i_max = 15'd1000;
    logic [QW-1:0]        cfg_q_min = 8'd50;
    wire signed [IW-1:0]  id_lim, iq_lim;
    wire                  lim_valid, freeze_req, trip_req, ev_enter, ev_exit;
    wire [1:0]            mode;

    int checks = 0;
    int errors = 0;

    int got_mode, got_enter, got_exit, got_freeze, got_trip, got_id, got_iq;
    logic got_valid;

    always #2.5 clk = ~clk;

    ridethru_ctrl #(.VW(VW), .QW(QW), .IW(IW), .CW(CW)) dut_i (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .v_mag(v_mag), .q_level(q_level),
        .id_ref(id_ref), .iq_ref(iq_ref), .cfg_v_dip(cfg_v_dip), .cfg_v_hyst(cfg_v_hyst),
        .cfg_recov_n(cfg_recov_n), .cfg_ride_max(cfg_ride_max), .cfg_i_max(cfg_i_max),
        .cfg_q_min(cfg_q_min), .id_lim(id_lim), .iq_lim(iq_lim), .lim_valid(lim_valid),
        .mode(mode), .freeze_req(freeze_req), .trip_req(trip_req),
        .ev_enter(ev_enter), .ev_exit(ev_exit)
    );

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic int isq(input int r);
        int s = 0;
        while ((s + 1) * (s + 1) <= r) s++;
        return s;
    endfunction

    // Expected limited references for a given mode (R2, R3, R4, R8)
    task automatic expect_refs(input string rq, input int m, input int idv, input int iqv);
        int lim = int'(cfg_i_max);
        int eq, ed, h;
        if (m == 3) begin
            ed = 0; eq = 0;
        end else if (m == 0) begin
            ed = idv; eq = iqv;
        end else begin
            eq = (iqv > lim) ? lim : ((iqv < -lim) ? -lim : iqv);
            h  = isq(lim * lim - eq * eq);
            ed = (idv > h) ? h : ((idv < -h) ? -h : idv);
        end
        chk({rq, " id"}, got_id, ed);
        chk({rq, " iq"}, got_iq, eq);
    endtask

    task automatic send(input int v, input int q, input int idv, input int iqv);
        @(negedge clk);
        v_mag = VW'(v); q_level = QW'(q); id_ref = IW'(idv); iq_ref = IW'(iqv);
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        got_mode = int'(mode); got_enter = int'(ev_enter); got_exit = int'(ev_exit);
        got_freeze = int'(freeze_req); got_trip = int'(trip_req);
        got_valid = 1'b0;
        for (int k = 0; k < 40 && !got_valid; k++) begin
            @(negedge clk);
            if (lim_valid) begin
                got_valid = 1'b1;
                got_id = int'(id_lim);
                got_iq = int'(iq_lim);
            end
        end
        chk("R10 lim_valid pulse", int'(got_valid), 1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 reset mode", int'(mode), 0);
        chk("R10 reset trip", int'(trip_req), 0);
        chk("R10 reset freeze", int'(freeze_req), 0);
        chk("R10 reset events", int'({ev_enter, ev_exit}), 0);
        chk("R10 reset outputs", int'(id_lim) + int'(iq_lim) + int'(lim_valid), 0);
    endtask

    task automatic t_normal();
        send(1200, 100, 1500, -300);
        chk("R4 mode normal", got_mode, 0);
        expect_refs("R4 passthrough", 0, 1500, -300);
        send(1000, 100, -2000, 2000);          // R1: equal to dip level is not a dip
        chk("R1 boundary no entry", got_mode, 0);
        chk("R1 boundary no event", got_enter, 0);
        expect_refs("R4 passthrough wide", 0, -2000, 2000);
    endtask

    task automatic t_dip();
        send(999, 100, 900, 600);
        chk("R1 enter ride", got_mode, 1);
        chk("R7 enter event", got_enter, 1);
        expect_refs("R3 headroom", 1, 900, 600);
        send(500, 100, 100, -1500);
        chk("R7 enter event single", got_enter, 0);
        expect_refs("R2 iq clamp zero headroom", 1, 100, -1500);
        send(500, 100, -900, 0);
        expect_refs("R3 negative id inside", 1, -900, 0);
        send(500, 100, -2000, 800);
        expect_refs("R3 negative id saturate", 1, -2000, 800);
    endtask

    task automatic t_recover();
        send(1099, 100, 0, 0);
        chk("R5 below recovery level", got_mode, 1);
        send(1100, 100, 2000, 0);
        chk("R5 enter recovery", got_mode, 2);
        expect_refs("R2 recovery limit", 2, 2000, 0);
        send(1050, 100, 0, 0);
        chk("R6 between levels", got_mode, 2);
        send(1200, 100, 0, 0);
        chk("R6 count 1 after restart", got_mode, 2);
        send(1200, 100, 0, 0);
        chk("R6 count 2", got_mode, 2);
        send(900, 100, 0, 0);
        chk("R6 dip back to ride", got_mode, 1);
        chk("R6 no re-entry event", got_enter, 0);
        send(1150, 100, 0, 0);
        chk("R6 recovery again", got_mode, 2);
        send(1150, 100, 0, 0);
        chk("R6 count 2 again", got_mode, 2);
        chk("R7 no early exit", got_exit, 0);
        send(1150, 100, 2000, 0);
        chk("R6 back to normal", got_mode, 0);
        chk("R7 exit event", got_exit, 1);
        expect_refs("R4 passthrough after exit", 0, 2000, 0);
    endtask

    task automatic t_freeze();
        send(1200, 30, 0, 0);
        chk("R9 freeze set", got_freeze, 1);
        repeat (5) @(negedge clk);
        chk("R9 freeze held", int'(freeze_req), 1);
        send(1200, 50, 0, 0);
        chk("R9 freeze clear at threshold", got_freeze, 0);
    endtask

    task automatic t_trip();
        cfg_ride_max = 16'd5;
        t_reset();
        for (int n = 1; n <= 5; n++) begin
            send(500, 100, 0, 0);
            chk("R8 within budget", got_mode, 1);
        end
        send(500, 100, 700, 300);
        chk("R8 tripped mode", got_mode, 3);
        chk("R8 trip request", got_trip, 1);
        expect_refs("R8 zero refs", 3, 700, 300);
        send(1200, 100, 0, 0);
        send(1200, 100, 0, 0);
        chk("R8 trip sticky", got_mode, 3);
        chk("R8 trip sticky request", got_trip, 1);
        chk("R8 no exit event", got_exit, 0);
        t_reset();
        cfg_ride_max = 16'd20;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_normal();
        t_dip();
        t_recover();
        t_freeze();
        t_trip();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule